// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the ordered list of column addresses a synchronous DRAM array visits during that burst. A one-cycle start pulse captures a starting column, a length code and an ordering bit. From the next cycle on, the block presents one column address per beat on a valid/ready output stream and flags the final beat. Fixed bursts of 1, 2, 4 or 8 beats stay inside the naturally aligned block that holds the starting column. They visit it either in counting order with wrap-around or in the XOR-with-beat-index order. A full-page burst walks the entire column space, wrapping from the top column back to zero, until the terminate input ends it.

The output is a stream. A beat is consumed on a cycle where `col_valid` and `col_ready` are both high. While `col_valid` is high and `col_ready` is low, the address is held. `col_valid` does not depend on `col_ready`. A new start pulse always wins: it abandons any burst in progress, including one whose final beat is being consumed in the same cycle.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `col_valid` and `col_last` are low until the first start pulse.
- R2: In the cycle after `start` is high, `col_valid` is high and `col_addr` equals the `start_col` sampled with the pulse. A start during an active burst abandons that burst, and the new one begins from beat 0.
- R3: A beat advances only on a cycle where `col_valid` and `col_ready` are both high. While the stream is stalled, `col_addr` is unchanged in the next cycle.
- R4: `len_code` values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Any value with bit 2 set selects a full-page burst.
- R5: With `interleave` low and a fixed length N, beat k presents the address whose bits below log2(N) equal (start + k) mod N. The bits above log2(N) stay equal to those of the start column.
- R6: With `interleave` high and a fixed length N, beat k presents the address whose bits below log2(N) equal start XOR k. The upper bits are unchanged.
- R7: In a full-page burst, beat k presents (start + k) mod 2^COL_W and `interleave` has no effect. With the default COL_W of 9 this is mod 512. The burst continues past 2^COL_W beats.
- R8: In a fixed burst, `col_last` is high exactly on beat N-1. After that beat is consumed, `col_valid` is low in the next cycle unless a start arrives.
- R9: In a full-page burst, `col_last` follows `terminate`, and consuming a beat with `terminate` high ends the burst. `terminate` has no effect during fixed bursts or while idle.
- R10: When a start pulse coincides with the consumption of a final beat, the next cycle shows the new burst's beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a burst |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Length: 0..3 give 1/2/4/8 beats, bit 2 set gives full page |
| interleave | input | 1 | 1 selects XOR ordering for fixed bursts |
| terminate | input | 1 | Ends a full-page burst on the current beat |
| col_valid | output | 1 | A column address is presented |
| col_ready | input | 1 | Consumer accepts the presented address |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one |

## Verification
The interesting collisions are a start pulse landing in the same cycle as the handshake that consumes a burst's final beat, and a start landing mid-burst while a beat is stalled. The bench parks a burst on its last beat and then raises `start` and `col_ready` together. It judges the result by requiring the following cycle to show the new start column with `col_valid` high, not an idle gap. It also interrupts an 8-beat burst part way and checks that the new burst's ordering and length are followed from beat 0.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [1:0] {
    ORD_COUNT = 2'd0,
    ORD_XOR   = 2'd1,
    ORD_PAGE  = 2'd2
  } order_e;

  typedef struct packed {
    order_e     order;
    logic [1:0] span_log;
  } burst_cfg_t;

  function automatic burst_cfg_t decode_cfg(input logic [2:0] code, input logic il);
    burst_cfg_t c;
    c.span_log = code[1:0];
    if (code[2])  c.order = ORD_PAGE;
    else if (il)  c.order = ORD_XOR;
    else          c.order = ORD_COUNT;
    return c;
  endfunction

endpackage

// File: rtl/bcs_cfg_latch.sv
module bcs_cfg_latch
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] col_in,
  input  logic [2:0]       code_in,
  input  logic             il_in,
  output logic [COL_W-1:0] col_q,
  output burst_cfg_t       cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      cfg_q <= '{order: ORD_COUNT, span_log: 2'd0};
    end else if (load) begin
      col_q <= col_in;
      cfg_q <= decode_cfg(code_in, il_in);
    end
  end

endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             fire,
  input  logic             finish,
  output logic             active,
  output logic [COL_W-1:0] beat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (load) begin
      active <= 1'b1;
      beat   <= '0;
    end else if (fire) begin
      beat <= beat + 1'b1;
      if (finish) active <= 1'b0;
    end
  end

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat,
  input  burst_cfg_t       cfg,
  output logic [COL_W-1:0] addr
);

  logic [COL_W-1:0] summed;
  logic [COL_W-1:0] xored;
  logic [COL_W-1:0] in_win;

  assign summed = base_col + beat;
  assign xored  = base_col ^ beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign in_win[i] = (cfg.order == ORD_PAGE) || (i < int'(cfg.span_log));
    assign addr[i]   = !in_win[i]             ? base_col[i] :
                       (cfg.order == ORD_XOR) ? xored[i]    : summed[i];
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  input  logic             terminate,
  output logic             col_valid,
  input  logic             col_ready,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last
);

  logic [COL_W-1:0] base_col;
  burst_cfg_t       cfg;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] final_beat;
  logic             active;
  logic             fire;

  bcs_cfg_latch #(.COL_W(COL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(start),
    .col_in(start_col), .code_in(len_code), .il_in(interleave),
    .col_q(base_col), .cfg_q(cfg)
  );

  bcs_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(start),
    .fire(fire), .finish(col_last),
    .active(active), .beat(beat)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_col(base_col), .beat(beat), .cfg(cfg), .addr(col_addr)
  );

  assign final_beat = COL_W'((1 << cfg.span_log) - 1);
  assign col_valid  = active;
  assign fire       = col_valid & col_ready;
  assign col_last   = active & ((cfg.order == ORD_PAGE) ? terminate : (beat == final_beat));

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && col_addr == $past(start_col)); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_ready && !start |=> col_valid && $stable(col_addr)); // R3
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && col_ready && col_last && !start |=> !col_valid); // R8
  AST_MID_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && col_ready && !col_last && !start |=> col_valid); // R8
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid); // R9

endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic interleave = 1'b0;
  logic terminate = 1'b0;
  logic col_ready = 1'b0;
  logic col_valid;
  logic [COL_W-1:0] col_addr;
  logic col_last;

  int n_chk = 0;
  int n_fail = 0;
  int pat = 0;
  int wd = 0;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .interleave(interleave), .terminate(terminate),
    .col_valid(col_valid), .col_ready(col_ready), .col_addr(col_addr),
    .col_last(col_last)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", wd);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_addr(int col, int code, bit il, int k);
    int n, off, base;
    if (code >= 4) return (col + k) % PAGE;
    n = 1 << code;
    off = col % n;
    base = col - off;
    if (il) return base + (off ^ (k % n));
    return base + ((off + k) % n);
  endfunction

  task automatic kick(int col, int code, bit il);
    start = 1'b1; start_col = COL_W'(col); len_code = 3'(code);
    interleave = il; col_ready = 1'b0; terminate = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Called at a negedge; follows beats from k=0 until completion or until stop_at beats consumed.
  task automatic follow(int col, int code, bit il, int stop_at, int term_at);
    int k = 0;
    bit done = 0;
    bit page = (code >= 4);
    bit exp_last;
    while (!done && k != stop_at) begin
      pat++;
      col_ready = ((pat % 5) != 3);
      if (page) begin
        terminate = (k == term_at);
        if (terminate) col_ready = 1'b1;
      end else begin
        terminate = k[0];
      end
      #1;
      exp_last = page ? (k == term_at) : (k == (1 << code) - 1);
      chk(col_valid === 1'b1, page ? "R7 valid" : "R4 valid", int'(col_valid), 1);
      chk(col_addr === COL_W'(exp_addr(col, code, il, k)),
          page ? "R7 addr" : (il ? "R6 addr" : "R5 addr"),
          int'(col_addr), exp_addr(col, code, il, k));
      chk(col_last === exp_last, page ? "R9 last" : "R8 last", int'(col_last), int'(exp_last));
      if (col_ready) begin
        k++;
        if (exp_last) done = 1;
      end
      @(negedge clk);
    end
    terminate = 1'b0;
    col_ready = 1'b0;
    if (done) begin
      #1;
      chk(col_valid === 1'b0, "R8 idle after last", int'(col_valid), 0);
    end
  endtask

  initial begin
    #1;
    chk(col_valid === 1'b0, "R1 valid in reset", int'(col_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    terminate = 1'b1; col_ready = 1'b1;
    #1;
    chk(col_valid === 1'b0, "R1 idle valid", int'(col_valid), 0);
    chk(col_last === 1'b0, "R9 terminate ignored while idle", int'(col_last), 0);
    @(negedge clk);
    terminate = 1'b0; col_ready = 1'b0;

    // Sweep every start column, every fixed length and both orderings
    for (int code = 0; code < 4; code++)
      for (int il = 0; il < 2; il++)
        for (int col = 0; col < PAGE; col++) begin
          kick(col, code, il[0]);
          follow(col, code, il[0], -1, -1);
        end

    // Full page wraps past the top and ignores interleave (R7, R9)
    kick(500, 7, 1'b1);
    follow(500, 7, 1'b1, -1, PAGE + 7);
    for (int code = 4; code < 7; code++) begin
      kick(37 * code, code, 1'b0);
      follow(37 * code, code, 1'b0, -1, 5);
    end

    // Restart in mid burst (R2)
    kick(5, 3, 1'b0);
    follow(5, 3, 1'b0, 3, -1);
    kick(40, 2, 1'b1);
    follow(40, 2, 1'b1, -1, -1);

    // Start together with the final-beat handshake (R10)
    kick(13, 2, 1'b0);
    follow(13, 2, 1'b0, 3, -1);
    #1;
    chk(col_last === 1'b1, "R10 parked on last", int'(col_last), 1);
    col_ready = 1'b1;
    start = 1'b1; start_col = COL_W'(200); len_code = 3'd3; interleave = 1'b1;
    @(negedge clk);
    start = 1'b0; col_ready = 1'b0;
    #1;
    chk(col_valid === 1'b1, "R10 new burst valid", int'(col_valid), 1);
    chk(col_addr === COL_W'(200), "R10 new burst addr", int'(col_addr), 200);
    @(negedge clk);
    follow(200, 3, 1'b1, -1, -1);

    summary();
    $finish;
  end

endmodule